// File: doc/BRIEF.md
# Power-Fail Protected Byte SRAM

This block models a 2,048-byte static memory with the three active-low controls of an asynchronous SRAM: chip select, output enable and write strobe. All of them are sampled on a system clock. A two-bit supply-status input stands in for an analog voltage monitor. The block decodes an operating mode from the supply status and the three controls, and it writes or reads one byte per access. It drives a data-out bus together with an output-enable flag, which models three-state pins, and a data-valid flag. Whenever the supply is out of tolerance, the block ignores every control, refuses writes and keeps its outputs off. The stored bytes survive every supply state.

A write is open for as long as the controls request it. The block captures the address and data on every cycle of that write and commits the last captured byte to the array in the first cycle that leaves write mode with the supply still good. If the supply drops while the write is open, the write is discarded.

A read reaches the output a fixed number of clock cycles after its address or enables last changed. During that window the valid flag is low and the previous byte stays on the bus. The pins are those of a memory device, so the edge has no stream handshake and no back-pressure. Every access completes in a bounded number of cycles.

Top module: `pfp_sram`

## Requirements
- R1: The array holds 2,048 bytes selected by an 11-bit address. A read returns the last byte committed at that address, including addresses 0 and 2047.
- R2: With supply status 00 and `ce_n` high, the block is in standby. One edge later `dout_en`, `dout_valid` and `dout` are all 0, and no byte is written, even if `we_n` is low.
- R3: With supply status 00, `ce_n` low and `we_n` low, a write is open. `oe_n` has no effect and the outputs are disabled one edge later. The byte captured in the last write cycle is stored at the edge of the first cycle that is out of write mode with status 00.
- R4: With supply status 00, `ce_n` low, `we_n` high and `oe_n` low, the addressed byte is driven. After RD_LAT edges with stable inputs, `dout_en` = 1, `dout_valid` = 1 and `dout` equals the stored byte.
- R5: With supply status 00, `ce_n` low, `we_n` high and `oe_n` high, the read is active but `dout_en` = 0 and `dout` = 0. Nothing is stored.
- R6: A change of address, or a change of `oe_n`, during a read starts a new access. For RD_LAT-1 edges afterwards, `dout_valid` is 0 and `dout` keeps the previous byte. At the RD_LAT-th edge the new byte appears with `dout_valid` = 1.
- R7: Supply status 01 (power-fail region) makes the block ignore all controls. One edge later the outputs are 0, and no write is performed.
- R8: Supply status 10 or 11 (battery backup) also makes the block ignore all controls, with outputs 0. Stored bytes are unchanged when status returns to 00.
- R9: A write that is open when the supply status leaves 00 is aborted. The addressed byte keeps its previous value.
- R10: A read that starts in the cycle right after a write to the same address returns the newly written byte.
- R11: While `rst_n` is low, `dout_en`, `dout_valid` and `dout` are 0 and any open write is dropped. The array contents are not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all controls are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| pwr_state | input | 2 | Supply status: 00 good, 01 power-fail region, 10/11 battery backup |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write strobe |
| addr | input | 11 | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, forced to 0 while outputs are disabled |
| dout_en | output | 1 | Output-drive flag modelling the three-state pins |
| dout_valid | output | 1 | High when `dout` carries a completed access |

## Verification
The hardest situation to reach is a write that is still open when the supply leaves the good state. A write commits only on the cycle after the strobe is released, so the stimulus has to drop the supply status while the write controls stay asserted. It then restores good supply with the chip deselected and reads the address back to confirm the old byte. The bench also builds the block with a read latency of three. This opens a visible window after an address change, so the bench can check the held old byte and the low valid flag on each intermediate edge.

// File: rtl/pfp_sram_pkg.sv
package pfp_sram_pkg;

  localparam logic [1:0] PWR_GOOD = 2'b00;
  localparam logic [1:0] PWR_FAIL = 2'b01;

  typedef enum logic [2:0] {
    MODE_STANDBY  = 3'd0,
    MODE_WRITE    = 3'd1,
    MODE_READ_OUT = 3'd2,
    MODE_READ_HIZ = 3'd3,
    MODE_PWRFAIL  = 3'd4,
    MODE_BATTERY  = 3'd5
  } mode_e;

  function automatic logic mode_is_read(mode_e m);
    return (m == MODE_READ_OUT) || (m == MODE_READ_HIZ);
  endfunction

endpackage

// File: rtl/pfp_sram_mode.sv
module pfp_sram_mode
  import pfp_sram_pkg::*;
(
  input  logic [1:0] pwr_state,
  input  logic       ce_n,
  input  logic       we_n,
  input  logic       oe_n,
  output mode_e      mode
);

  always_comb begin
    if (pwr_state == PWR_FAIL) begin
      mode = MODE_PWRFAIL;
    end else if (pwr_state != PWR_GOOD) begin
      mode = MODE_BATTERY;      // 10 and 11 both mean battery backup
    end else if (ce_n) begin
      mode = MODE_STANDBY;
    end else if (!we_n) begin
      mode = MODE_WRITE;        // strobe wins over output enable
    end else if (!oe_n) begin
      mode = MODE_READ_OUT;
    end else begin
      mode = MODE_READ_HIZ;
    end
  end

endmodule

// File: rtl/pfp_sram_wrctl.sv
module pfp_sram_wrctl
  import pfp_sram_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          commit,
  output logic [AW-1:0] commit_addr,
  output logic [DW-1:0] commit_data
);

  logic          open_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          supply_ok;

  assign supply_ok   = (mode != MODE_PWRFAIL) && (mode != MODE_BATTERY);
  // The write lands when the cycle leaves write mode with good supply;
  // a supply drop clears the open write without landing it.
  assign commit      = open_q && supply_ok && (mode != MODE_WRITE);
  assign commit_addr = addr_q;
  assign commit_data = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else if (mode == MODE_WRITE) begin
      open_q <= 1'b1;
      addr_q <= addr;
      data_q <= din;
    end else begin
      open_q <= 1'b0;
    end
  end

endmodule

// File: rtl/pfp_sram_array.sv
module pfp_sram_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  // No reset: contents persist through every supply state and reset.
  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= wr_data;
  end

  assign rd_data = cells[rd_addr];

endmodule

// File: rtl/pfp_sram_rdpath.sv
module pfp_sram_rdpath
  import pfp_sram_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic [AW-1:0] addr,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_data,
  input  logic          fwd_en,
  input  logic [AW-1:0] fwd_addr,
  input  logic [DW-1:0] fwd_data,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          dout_valid
);

  localparam int            AGE_W = $clog2(RD_LAT + 1);
  localparam logic [AGE_W-1:0] AGE_DONE = AGE_W'(RD_LAT);
  localparam logic [AGE_W-1:0] AGE_ONE  = AGE_W'(1);

  logic             reading;
  logic             was_reading_q;
  logic [AW:0]      key, key_q;
  logic             new_access;
  logic [AGE_W-1:0] age_q, age_nxt;
  logic [DW-1:0]    byte_q, src_byte;
  logic             en_q;

  assign reading    = mode_is_read(mode);
  assign key        = {addr, oe_n};
  assign new_access = !was_reading_q || (key != key_q);
  assign src_byte   = (fwd_en && fwd_addr == addr) ? fwd_data : arr_data;

  always_comb begin
    if (!reading)             age_nxt = '0;
    else if (new_access)      age_nxt = AGE_ONE;
    else if (age_q == AGE_DONE) age_nxt = AGE_DONE;
    else                      age_nxt = age_q + AGE_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_reading_q <= 1'b0;
      key_q         <= '0;
      age_q         <= '0;
      byte_q        <= '0;
      en_q          <= 1'b0;
    end else begin
      was_reading_q <= reading;
      key_q         <= key;
      age_q         <= age_nxt;
      en_q          <= (mode == MODE_READ_OUT);
      // Old byte is held through the latency window.
      if (reading && age_nxt == AGE_DONE) byte_q <= src_byte;
    end
  end

  assign dout_en    = en_q;
  assign dout       = en_q ? byte_q : '0;
  assign dout_valid = en_q && (age_q == AGE_DONE);

endmodule

// File: rtl/pfp_sram.sv
module pfp_sram
  import pfp_sram_pkg::*;
#(
  parameter int AW     = 11,
  parameter int DW     = 8,
  parameter int RD_LAT = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    pwr_state,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  output logic          dout_valid
);

  mode_e         mode;
  logic          commit;
  logic [AW-1:0] commit_addr;
  logic [DW-1:0] commit_data;
  logic [DW-1:0] arr_data;

  pfp_sram_mode u_mode (
    .pwr_state (pwr_state),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .mode      (mode)
  );

  pfp_sram_wrctl #(.AW(AW), .DW(DW)) u_wrctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .addr        (addr),
    .din         (din),
    .commit      (commit),
    .commit_addr (commit_addr),
    .commit_data (commit_data)
  );

  pfp_sram_array #(.AW(AW), .DW(DW)) u_array (
    .clk     (clk),
    .wr_en   (commit),
    .wr_addr (commit_addr),
    .wr_data (commit_data),
    .rd_addr (addr),
    .rd_data (arr_data)
  );

  pfp_sram_rdpath #(.AW(AW), .DW(DW), .RD_LAT(RD_LAT)) u_rdpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .addr       (addr),
    .oe_n       (oe_n),
    .arr_data   (arr_data),
    .fwd_en     (commit),
    .fwd_addr   (commit_addr),
    .fwd_data   (commit_data),
    .dout       (dout),
    .dout_en    (dout_en),
    .dout_valid (dout_valid)
  );

endmodule

// File: rtl/pfp_sram_chk.sv
module pfp_sram_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    pwr_state,
  input logic          ce_n,
  input logic          oe_n,
  input logic          we_n,
  input logic [DW-1:0] dout,
  input logic          dout_en,
  input logic          dout_valid
);

  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && ce_n) |=> (!dout_en && !dout_valid));

  // R3
  write_hides_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && !ce_n && !we_n) |=> !dout_en);

  // R5
  hiz_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && !ce_n && we_n && oe_n) |=> !dout_en);

  // R7
  pwrfail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b01) |=> (!dout_en && !dout_valid));

  // R8
  battery_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state[1]) |=> (!dout_en && !dout_valid));

  // R4
  drive_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b00 && !ce_n && we_n && !oe_n) |=> dout_en);

  // R6
  valid_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_valid |-> dout_en);

  // R11
  zero_when_off_chk: assert property (@(posedge clk)
    !dout_en |-> (dout == '0));

endmodule

bind pfp_sram pfp_sram_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pwr_state  (pwr_state),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .dout       (dout),
  .dout_en    (dout_en),
  .dout_valid (dout_valid)
);

// File: tb/pfp_sram_bench.sv
`timescale 1ns/1ps
module pfp_sram_bench;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  pwr_state;
  logic        ce_n, oe_n, we_n;
  logic [10:0] addr;
  logic [7:0]  din;
  logic [7:0]  dout;
  logic        dout_en, dout_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  pfp_sram #(.AW(11), .DW(8), .RD_LAT(LAT)) u_pfp_sram (
    .clk(clk), .rst_n(rst_n), .pwr_state(pwr_state),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din),
    .dout(dout), .dout_en(dout_en), .dout_valid(dout_valid)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(logic [1:0] p, logic c, logic w, logic o,
                       logic [10:0] a, logic [7:0] d);
    pwr_state = p; ce_n = c; we_n = w; oe_n = o; addr = a; din = d;
  endtask

  task automatic do_write(logic [10:0] a, logic [7:0] d);
    drive(2'b00, 1'b0, 1'b0, 1'b1, a, d);
    tick();
    drive(2'b00, 1'b1, 1'b1, 1'b1, a, 8'h00);
    tick();
  endtask

  task automatic read_expect(string req, logic [10:0] a, logic [7:0] exp);
    drive(2'b00, 1'b0, 1'b1, 1'b0, a, 8'h00);
    repeat (LAT) tick();
    check(req, {dout_en, dout_valid, dout}, {1'b1, 1'b1, exp});
    drive(2'b00, 1'b1, 1'b1, 1'b1, a, 8'h00);
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    drive(2'b00, 1'b0, 1'b1, 1'b0, 11'd5, 8'h00);
    repeat (4) tick();
    // R11: outputs held off during reset even with a read requested
    check("R11", {dout_en, dout_valid, dout}, 10'd0);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 8'h00);
    tick();
    rst_n = 1'b1;
    tick();
    check("R11", {dout_en, dout_valid, dout}, 10'd0);
  endtask

  task automatic t_basic();
    do_write(11'd0, 8'hA5);
    do_write(11'd2047, 8'h5A);
    do_write(11'h155, 8'hC3);
    read_expect("R1", 11'd0, 8'hA5);
    read_expect("R1", 11'd2047, 8'h5A);
    read_expect("R4", 11'h155, 8'hC3);
  endtask

  task automatic t_write_ignores_oe();
    drive(2'b00, 1'b0, 1'b0, 1'b0, 11'd9, 8'h77);
    tick();
    // R3: outputs off while writing, G low notwithstanding
    check("R3", {dout_en, dout}, 9'd0);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 11'd9, 8'h00);
    tick();
    read_expect("R3", 11'd9, 8'h77);
  endtask

  task automatic t_standby();
    drive(2'b00, 1'b1, 1'b0, 1'b0, 11'd0, 8'hFF);
    tick();
    check("R2", {dout_en, dout_valid, dout}, 10'd0);
    tick();
    // R2: no write while deselected
    read_expect("R2", 11'd0, 8'hA5);
  endtask

  task automatic t_read_hiz();
    drive(2'b00, 1'b0, 1'b1, 1'b1, 11'd0, 8'h00);
    repeat (LAT) tick();
    check("R5", {dout_en, dout_valid, dout}, 10'd0);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 8'h00);
    tick();
    read_expect("R5", 11'd0, 8'hA5);
  endtask

  task automatic t_latency();
    drive(2'b00, 1'b0, 1'b1, 1'b0, 11'd0, 8'h00);
    repeat (LAT) tick();
    check("R6", {dout_valid, dout}, {1'b1, 8'hA5});
    addr = 11'd2047;
    tick();
    // R6: hold window, old byte kept, valid low
    check("R6", {dout_en, dout_valid, dout}, {1'b1, 1'b0, 8'hA5});
    tick();
    check("R6", {dout_en, dout_valid, dout}, {1'b1, 1'b0, 8'hA5});
    tick();
    check("R6", {dout_en, dout_valid, dout}, {1'b1, 1'b1, 8'h5A});
    drive(2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 8'h00);
    tick();
  endtask

  task automatic t_pwrfail();
    drive(2'b01, 1'b0, 1'b0, 1'b1, 11'h155, 8'h11);
    tick();
    tick();
    check("R7", {dout_en, dout_valid, dout}, 10'd0);
    drive(2'b01, 1'b0, 1'b1, 1'b0, 11'h155, 8'h00);
    repeat (LAT) tick();
    check("R7", {dout_en, dout_valid, dout}, 10'd0);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 11'h155, 8'h00);
    tick();
    read_expect("R7", 11'h155, 8'hC3);
  endtask

  task automatic t_battery();
    drive(2'b10, 1'b0, 1'b0, 1'b0, 11'd2047, 8'h22);
    tick();
    tick();
    check("R8", {dout_en, dout_valid, dout}, 10'd0);
    drive(2'b11, 1'b0, 1'b1, 1'b0, 11'd2047, 8'h33);
    repeat (LAT) tick();
    check("R8", {dout_en, dout_valid, dout}, 10'd0);
    drive(2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 8'h00);
    tick();
    read_expect("R8", 11'd2047, 8'h5A);
  endtask

  task automatic t_abort();
    drive(2'b00, 1'b0, 1'b0, 1'b1, 11'd0, 8'hEE);
    tick();
    pwr_state = 2'b01;     // supply drops with the write still open
    tick();
    drive(2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 8'h00);
    tick();
    read_expect("R9", 11'd0, 8'hA5);
  endtask

  task automatic t_write_then_read();
    drive(2'b00, 1'b0, 1'b0, 1'b1, 11'd300, 8'h3C);
    tick();
    drive(2'b00, 1'b0, 1'b1, 1'b0, 11'd300, 8'h00);
    repeat (LAT) tick();
    check("R10", {dout_en, dout_valid, dout}, {1'b1, 1'b1, 8'h3C});
    drive(2'b00, 1'b1, 1'b1, 1'b1, 11'd0, 8'h00);
    tick();
  endtask

  initial begin
    t_reset();
    t_basic();
    t_write_ignores_oe();
    t_standby();
    t_read_hiz();
    t_latency();
    t_pwrfail();
    t_battery();
    t_abort();
    t_write_then_read();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int cyc = 0; cyc < 20000; cyc++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule